// File: doc/BRIEF.md
# SPI Master with Programmable Delays

This block is a mode-0 SPI master. Each transfer is built in three levels: words of a fixed bit count, frames made of words, and transfers made of frames. Software or a sequencer sets a per-transfer command that gives the word and frame counts, four delay values and a flag that keeps the select asserted. Data words arrive on a transmit stream, and received words leave on a receive stream. Both streams use valid/ready handshakes.

Every point of the select/clock sequence can be stretched by a delay counted in system-clock cycles:
- the time from select assertion to the first clock;
- the idle gap between words of one frame;
- the idle gap between frames of one transfer;
- the time from the last clock to select release;
- the minimum time the select stays released before the next transfer.

The release time is the sum of a static device-level value and a per-transfer change value. When the keep flag is set, the select stays low and the next transfer starts clocking without a setup wait.

Top module: `spi_delay_master`

## Requirements
- R1: After reset, csN is 1, sclk is 0, busy is 0, done is 0, rxValid is 0 and cmdReady is 1.
- R2: A command carrying cmdWordsM1=a and cmdFramesM1=b shifts (a+1)*(b+1) words, taking one word from the transmit stream per word. Each word gives WORD_BITS sclk pulses, and mosi carries the word most significant bit first.
- R3: sclk idles low and never pulses while csN is 1. Each sclk phase lasts cfgDiv+1 cycles. mosi changes only while sclk is low. miso is sampled on each rising edge, and the word on rxData holds those samples with the first sample as the most significant bit.
- R4: The first rising sclk edge of a transfer comes cmdSetup+cfgDiv+2 cycles after csN falls.
- R5: Between two words of one frame, sclk stays low for cmdWordGap+cfgDiv+3 cycles, measured from the last falling edge to the next rising edge.
- R6: Between two frames, sclk stays low for cmdFrameGap+cfgDiv+3 cycles and csN stays low.
- R7: csN rises cmdHold+1 cycles after the last falling sclk edge of a transfer whose keep flag is 0.
- R8: After csN rises, busy stays high for cfgInactive+cmdChange more cycles. A command already waiting then makes csN fall one cycle later, so csN stays high for cfgInactive+cmdChange+1 cycles.
- R9: With cmdKeep=1, csN stays low after the transfer and busy falls together with done. The next transfer gives its first rising edge cfgDiv+3 cycles after that done, whatever its cmdSetup is.
- R10: done is a one-cycle pulse one cycle after the final falling sclk edge of a transfer. A command offered while busy is not accepted.
- R11: A received word stays on rxData with rxValid high until rxReady is seen. While it waits, no new word starts and sclk does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgDiv | input | DIV_W | sclk phase length minus one, in cycles (static) |
| cfgInactive | input | DLY_W | Device-level release time (static) |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Command accepted when high with cmdValid |
| cmdWordsM1 | input | CNT_W | Words per frame minus one |
| cmdFramesM1 | input | CNT_W | Frames per transfer minus one |
| cmdSetup | input | DLY_W | Select-to-first-clock delay |
| cmdWordGap | input | DLY_W | Delay between words of a frame |
| cmdFrameGap | input | DLY_W | Delay between frames |
| cmdHold | input | DLY_W | Last-clock-to-release delay |
| cmdChange | input | DLY_W | Per-transfer extra release time |
| cmdKeep | input | 1 | Keep select asserted after the transfer |
| txValid | input | 1 | Transmit word offered |
| txReady | output | 1 | Transmit word taken |
| txData | input | WORD_BITS | Transmit word |
| rxValid | output | 1 | Received word available |
| rxReady | input | 1 | Received word taken |
| rxData | output | WORD_BITS | Received word |
| busy | output | 1 | Transfer in progress, including release time |
| done | output | 1 | One-cycle pulse when the final word completes |
| csN | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bound checker watches the invariants that hold on every cycle:
- no clock pulse outside the select;
- mosi stable while sclk is high;
- a pending received word held steady and blocking new transmit words;
- done being a single-cycle pulse that comes only after selection.

The exact cycle counts of the five delays can only be shown by the directed scenarios. These counts are the setup, word and frame gaps, hold and release time. The scenarios also show the bit order on mosi, the keep-select continuation and the handling of back-to-back commands. The bench records the time of every sclk rise and every select edge and compares each one against positions it computes from the programmed values.

// File: rtl/spi_dly_pkg.sv
package spi_dly_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOAD,
    ST_SHIFT,
    ST_GAP,
    ST_HOLD,
    ST_INACT
  } ctrlState_t;

  // strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic loadWord;  // start shifting the presented transmit word
    logic clrRx;     // received word handed over, drop the valid flag
  } dpCtrl_t;

endpackage

// File: rtl/spi_dly_dp.sv
module spi_dly_dp
  import spi_dly_pkg::*;
#(
  parameter int WORD_BITS = 8,
  parameter int DIV_W     = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtrl_t              ctl,
  input  logic [WORD_BITS-1:0] txWord,
  input  logic [DIV_W-1:0]     halfDiv,
  input  logic                 miso,
  output logic                 sclk,
  output logic                 mosi,
  output logic                 wordDone,
  output logic                 rxValid,
  output logic [WORD_BITS-1:0] rxWord
);

  localparam int BIT_W = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_BITS - 1);

  logic                 active;
  logic                 sclkR;
  logic [DIV_W-1:0]     phaseCnt;
  logic [BIT_W-1:0]     bitCnt;
  logic [WORD_BITS-1:0] txShift;
  logic [WORD_BITS-1:0] rxShift;
  logic [WORD_BITS-1:0] rxHold;
  logic                 rxFlag;
  logic                 doneR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      sclkR    <= 1'b0;
      phaseCnt <= '0;
      bitCnt   <= '0;
      txShift  <= '0;
      rxShift  <= '0;
      rxHold   <= '0;
      rxFlag   <= 1'b0;
      doneR    <= 1'b0;
    end else begin
      doneR <= 1'b0;
      if (ctl.clrRx) rxFlag <= 1'b0;
      if (ctl.loadWord) begin
        active   <= 1'b1;
        sclkR    <= 1'b0;
        phaseCnt <= '0;
        bitCnt   <= '0;
        txShift  <= txWord;
      end else if (active) begin
        if (phaseCnt == halfDiv) begin
          phaseCnt <= '0;
          if (!sclkR) begin
            // rising edge: capture the incoming bit
            sclkR   <= 1'b1;
            rxShift <= {rxShift[WORD_BITS-2:0], miso};
          end else begin
            // falling edge: advance the outgoing bit or close the word
            sclkR <= 1'b0;
            if (bitCnt == LAST_BIT) begin
              active <= 1'b0;
              doneR  <= 1'b1;
              rxHold <= rxShift;
              rxFlag <= 1'b1;
            end else begin
              bitCnt  <= bitCnt + 1'b1;
              txShift <= {txShift[WORD_BITS-2:0], 1'b0};
            end
          end
        end else begin
          phaseCnt <= phaseCnt + 1'b1;
        end
      end
    end
  end

  assign sclk     = sclkR;
  assign mosi     = txShift[WORD_BITS-1];
  assign wordDone = doneR;
  assign rxValid  = rxFlag;
  assign rxWord   = rxHold;

endmodule

// File: rtl/spi_dly_ctrl.sv
module spi_dly_ctrl
  import spi_dly_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DLY_W-1:0] cfgInactive,
  input  logic             cmdValid,
  output logic             cmdReady,
  input  logic [CNT_W-1:0] cmdWordsM1,
  input  logic [CNT_W-1:0] cmdFramesM1,
  input  logic [DLY_W-1:0] cmdSetup,
  input  logic [DLY_W-1:0] cmdWordGap,
  input  logic [DLY_W-1:0] cmdFrameGap,
  input  logic [DLY_W-1:0] cmdHold,
  input  logic [DLY_W-1:0] cmdChange,
  input  logic             cmdKeep,
  input  logic             txValid,
  output logic             txReady,
  input  logic             wordDone,
  input  logic             rxValid,
  input  logic             rxReady,
  output logic             csN,
  output logic             busy,
  output logic             done,
  output dpCtrl_t          ctl
);

  localparam int SUM_W = DLY_W + 1;

  ctrlState_t       state;
  logic [SUM_W-1:0] dlyCnt;
  logic [CNT_W-1:0] wordIdx;
  logic [CNT_W-1:0] frameIdx;
  logic [CNT_W-1:0] rWordsM1;
  logic [CNT_W-1:0] rFramesM1;
  logic [DLY_W-1:0] rWordGap;
  logic [DLY_W-1:0] rFrameGap;
  logic [DLY_W-1:0] rHold;
  logic [DLY_W-1:0] rChange;
  logic             rKeep;
  logic             csR;
  logic             doneR;
  logic [SUM_W-1:0] inactSum;
  logic             lastWord;
  logic             lastFrame;

  assign inactSum  = SUM_W'(cfgInactive) + SUM_W'(rChange);
  assign lastWord  = (wordIdx == rWordsM1);
  assign lastFrame = (frameIdx == rFramesM1);

  assign txReady      = (state == ST_LOAD) && !rxValid;
  assign ctl.loadWord = txValid && txReady;
  assign ctl.clrRx    = rxValid && rxReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      dlyCnt    <= '0;
      wordIdx   <= '0;
      frameIdx  <= '0;
      rWordsM1  <= '0;
      rFramesM1 <= '0;
      rWordGap  <= '0;
      rFrameGap <= '0;
      rHold     <= '0;
      rChange   <= '0;
      rKeep     <= 1'b0;
      csR       <= 1'b1;
      doneR     <= 1'b0;
    end else begin
      doneR <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmdValid) begin
            rWordsM1  <= cmdWordsM1;
            rFramesM1 <= cmdFramesM1;
            rWordGap  <= cmdWordGap;
            rFrameGap <= cmdFrameGap;
            rHold     <= cmdHold;
            rChange   <= cmdChange;
            rKeep     <= cmdKeep;
            wordIdx   <= '0;
            frameIdx  <= '0;
            if (csR) begin
              csR <= 1'b0;
              if (cmdSetup != '0) begin
                state  <= ST_SETUP;
                dlyCnt <= SUM_W'(cmdSetup) - SUM_W'(1);
              end else begin
                state <= ST_LOAD;
              end
            end else begin
              // select still held from a kept transfer: no setup wait
              state <= ST_LOAD;
            end
          end
        end
        ST_SETUP, ST_GAP: begin
          if (dlyCnt == '0) state <= ST_LOAD;
          else              dlyCnt <= dlyCnt - 1'b1;
        end
        ST_LOAD: begin
          if (ctl.loadWord) state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (wordDone) begin
            if (lastWord && lastFrame) begin
              doneR <= 1'b1;
              if (rKeep) begin
                state <= ST_IDLE;
              end else if (rHold != '0) begin
                state  <= ST_HOLD;
                dlyCnt <= SUM_W'(rHold) - SUM_W'(1);
              end else begin
                csR <= 1'b1;
                if (inactSum != '0) begin
                  state  <= ST_INACT;
                  dlyCnt <= inactSum - SUM_W'(1);
                end else begin
                  state <= ST_IDLE;
                end
              end
            end else if (lastWord) begin
              wordIdx  <= '0;
              frameIdx <= frameIdx + 1'b1;
              if (rFrameGap != '0) begin
                state  <= ST_GAP;
                dlyCnt <= SUM_W'(rFrameGap) - SUM_W'(1);
              end else begin
                state <= ST_LOAD;
              end
            end else begin
              wordIdx <= wordIdx + 1'b1;
              if (rWordGap != '0) begin
                state  <= ST_GAP;
                dlyCnt <= SUM_W'(rWordGap) - SUM_W'(1);
              end else begin
                state <= ST_LOAD;
              end
            end
          end
        end
        ST_HOLD: begin
          if (dlyCnt == '0) begin
            csR <= 1'b1;
            if (inactSum != '0) begin
              state  <= ST_INACT;
              dlyCnt <= inactSum - SUM_W'(1);
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            dlyCnt <= dlyCnt - 1'b1;
          end
        end
        ST_INACT: begin
          if (dlyCnt == '0) state <= ST_IDLE;
          else              dlyCnt <= dlyCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmdReady = (state == ST_IDLE);
  assign busy     = (state != ST_IDLE);
  assign csN      = csR;
  assign done     = doneR;

endmodule

// File: rtl/spi_delay_master.sv
module spi_delay_master
  import spi_dly_pkg::*;
#(
  parameter int WORD_BITS = 8,
  parameter int CNT_W     = 8,
  parameter int DLY_W     = 16,
  parameter int DIV_W     = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DIV_W-1:0]     cfgDiv,
  input  logic [DLY_W-1:0]     cfgInactive,
  input  logic                 cmdValid,
  output logic                 cmdReady,
  input  logic [CNT_W-1:0]     cmdWordsM1,
  input  logic [CNT_W-1:0]     cmdFramesM1,
  input  logic [DLY_W-1:0]     cmdSetup,
  input  logic [DLY_W-1:0]     cmdWordGap,
  input  logic [DLY_W-1:0]     cmdFrameGap,
  input  logic [DLY_W-1:0]     cmdHold,
  input  logic [DLY_W-1:0]     cmdChange,
  input  logic                 cmdKeep,
  input  logic                 txValid,
  output logic                 txReady,
  input  logic [WORD_BITS-1:0] txData,
  output logic                 rxValid,
  input  logic                 rxReady,
  output logic [WORD_BITS-1:0] rxData,
  output logic                 busy,
  output logic                 done,
  output logic                 csN,
  output logic                 sclk,
  output logic                 mosi,
  input  logic                 miso
);

  dpCtrl_t dpCtl;
  logic    wordDone;

  spi_dly_ctrl #(
    .CNT_W(CNT_W),
    .DLY_W(DLY_W)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .cfgInactive(cfgInactive),
    .cmdValid   (cmdValid),
    .cmdReady   (cmdReady),
    .cmdWordsM1 (cmdWordsM1),
    .cmdFramesM1(cmdFramesM1),
    .cmdSetup   (cmdSetup),
    .cmdWordGap (cmdWordGap),
    .cmdFrameGap(cmdFrameGap),
    .cmdHold    (cmdHold),
    .cmdChange  (cmdChange),
    .cmdKeep    (cmdKeep),
    .txValid    (txValid),
    .txReady    (txReady),
    .wordDone   (wordDone),
    .rxValid    (rxValid),
    .rxReady    (rxReady),
    .csN        (csN),
    .busy       (busy),
    .done       (done),
    .ctl        (dpCtl)
  );

  spi_dly_dp #(
    .WORD_BITS(WORD_BITS),
    .DIV_W    (DIV_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (dpCtl),
    .txWord  (txData),
    .halfDiv (cfgDiv),
    .miso    (miso),
    .sclk    (sclk),
    .mosi    (mosi),
    .wordDone(wordDone),
    .rxValid (rxValid),
    .rxWord  (rxData)
  );

endmodule

// File: rtl/spi_dly_chk.sv
module spi_dly_chk #(
  parameter int WORD_BITS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 csN,
  input logic                 sclk,
  input logic                 mosi,
  input logic                 busy,
  input logic                 done,
  input logic                 txReady,
  input logic                 rxValid,
  input logic                 rxReady,
  input logic [WORD_BITS-1:0] rxData
);

  // R3
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  // R3
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R11
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |=> (rxValid && $stable(rxData)));

  // R11
  rx_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> !txReady);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  done_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(!csN));

  // R10
  tx_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> busy);

endmodule

bind spi_delay_master spi_dly_chk #(.WORD_BITS(WORD_BITS)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .csN    (csN),
  .sclk   (sclk),
  .mosi   (mosi),
  .busy   (busy),
  .done   (done),
  .txReady(txReady),
  .rxValid(rxValid),
  .rxReady(rxReady),
  .rxData (rxData)
);

// File: tb/spi_delay_master_tb_top.sv
module spi_delay_master_tb_top;

  localparam int WB  = 8;
  localparam int CW  = 8;
  localparam int DW  = 16;
  localparam int VW  = 8;
  localparam int MAXE = 512;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [VW-1:0] cfgDiv = '0;
  logic [DW-1:0] cfgInactive = '0;
  logic          cmdValid = 1'b0;
  logic          cmdReady;
  logic [CW-1:0] cmdWordsM1 = '0;
  logic [CW-1:0] cmdFramesM1 = '0;
  logic [DW-1:0] cmdSetup = '0;
  logic [DW-1:0] cmdWordGap = '0;
  logic [DW-1:0] cmdFrameGap = '0;
  logic [DW-1:0] cmdHold = '0;
  logic [DW-1:0] cmdChange = '0;
  logic          cmdKeep = 1'b0;
  logic          txValid = 1'b1;
  logic          txReady;
  logic [WB-1:0] txData;
  logic          rxValid;
  logic          rxReady = 1'b1;
  logic [WB-1:0] rxData;
  logic          busy, done, csN, sclk, mosi, miso;

  int nChk = 0;
  int nFail = 0;
  int cyc = 0;
  int txIdx = 0;
  int rxIdx = 0;

  // monitor records
  int riseT [MAXE];
  bit bitV  [MAXE];
  int nRise = 0;
  int csFallT [8];
  int csRiseT [8];
  int nCsFall = 0;
  int nCsRise = 0;
  int doneT [8];
  int nDone = 0;
  int busyFallT [8];
  int nBusyFall = 0;
  logic prevSclk = 1'b0, prevCs = 1'b1, prevBusy = 1'b0;

  always #5 clk = ~clk;

  assign miso = mosi;  // loopback

  function automatic logic [WB-1:0] txWord(int i);
    return WB'(i * 53 + 150);
  endfunction

  assign txData = txWord(txIdx);

  spi_delay_master #(.WORD_BITS(WB), .CNT_W(CW), .DLY_W(DW), .DIV_W(VW)) dut_i (
    .clk(clk), .rstN(rstN), .cfgDiv(cfgDiv), .cfgInactive(cfgInactive),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdWordsM1(cmdWordsM1),
    .cmdFramesM1(cmdFramesM1), .cmdSetup(cmdSetup), .cmdWordGap(cmdWordGap),
    .cmdFrameGap(cmdFrameGap), .cmdHold(cmdHold), .cmdChange(cmdChange),
    .cmdKeep(cmdKeep), .txValid(txValid), .txReady(txReady), .txData(txData),
    .rxValid(rxValid), .rxReady(rxReady), .rxData(rxData), .busy(busy),
    .done(done), .csN(csN), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  task automatic chk(bit ok, string tag, longint act, longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (txValid && txReady) txIdx <= txIdx + 1;
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (sclk && !prevSclk && nRise < MAXE) begin
        riseT[nRise] = cyc;
        bitV[nRise]  = mosi;
        nRise++;
      end
      if (!csN && prevCs && nCsFall < 8) begin csFallT[nCsFall] = cyc; nCsFall++; end
      if (csN && !prevCs && nCsRise < 8) begin csRiseT[nCsRise] = cyc; nCsRise++; end
      if (done && nDone < 8) begin doneT[nDone] = cyc; nDone++; end
      if (!busy && prevBusy && nBusyFall < 8) begin busyFallT[nBusyFall] = cyc; nBusyFall++; end
      if (rxValid && rxReady) begin
        // R3: received word equals sampled loopback bits, first sample as MSB
        chk(rxData == txWord(rxIdx), "R3 received word", longint'(rxData), longint'(txWord(rxIdx)));
        rxIdx++;
      end
      prevSclk = sclk;
      prevCs   = csN;
      prevBusy = busy;
    end
  end

  task automatic clearRec();
    nRise = 0; nCsFall = 0; nCsRise = 0; nDone = 0; nBusyFall = 0;
  endtask

  task automatic sendCmd(int w, int f, int s, int g, int fg, int h, int chg, bit keep);
    @(negedge clk);
    cmdWordsM1  = CW'(w - 1);
    cmdFramesM1 = CW'(f - 1);
    cmdSetup    = DW'(s);
    cmdWordGap  = DW'(g);
    cmdFrameGap = DW'(fg);
    cmdHold     = DW'(h);
    cmdChange   = DW'(chg);
    cmdKeep     = keep;
    cmdValid    = 1'b1;
    while (!cmdReady) @(negedge clk);
    @(posedge clk);
    #1 cmdValid = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy || cmdValid) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // compare recorded rising edges and mosi bits against computed positions
  task automatic checkXfer(int r0, int txBase, int l0, int nw, int nf, int d,
                           int g, int fg, string firstTag, output int lastFall);
    int l = l0;
    int n = r0;
    chk(nRise >= r0 + nw * nf * WB, "R2 sclk pulse count", nRise - r0, nw * nf * WB);
    for (int fr = 0; fr < nf; fr++) begin
      for (int w = 0; w < nw; w++) begin
        for (int j = 0; j < WB; j++) begin
          int expT = l + (d + 1) * (2 * j + 1);
          string tag;
          if (j > 0) tag = "R3 rise spacing";
          else if (fr == 0 && w == 0) tag = firstTag;
          else if (w == 0) tag = "R6 frame gap";
          else tag = "R5 word gap";
          if (n < MAXE) begin
            logic [WB-1:0] tw = txWord(txBase + fr * nw + w);
            chk(riseT[n] == expT, tag, riseT[n], expT);
            chk(bitV[n] == tw[WB-1-j], "R2 mosi bit order", bitV[n], tw[WB-1-j]);
          end
          n++;
        end
        lastFall = l + 2 * (d + 1) * WB;
        l = lastFall + 2 + ((w < nw - 1) ? g : fg);
      end
    end
  endtask

  task automatic testReset();
    // R1
    chk(csN == 1'b1, "R1 csN reset", csN, 1);
    chk(sclk == 1'b0, "R1 sclk reset", sclk, 0);
    chk(busy == 1'b0, "R1 busy reset", busy, 0);
    chk(done == 1'b0, "R1 done reset", done, 0);
    chk(rxValid == 1'b0, "R1 rxValid reset", rxValid, 0);
    chk(cmdReady == 1'b1, "R1 cmdReady reset", cmdReady, 1);
  endtask

  task automatic testBasic(int d, int w, int f, int s, int g, int fg, int h, int chg, int ina);
    int base, lastF;
    clearRec();
    cfgDiv = VW'(d);
    cfgInactive = DW'(ina);
    base = txIdx;
    sendCmd(w, f, s, g, fg, h, chg, 1'b0);
    waitIdle();
    chk(nCsFall == 1 && nCsRise == 1, "R6 select held across frames", nCsRise, 1);
    checkXfer(0, base, csFallT[0] + s + 1, w, f, d, g, fg, "R4 setup delay", lastF);
    chk(nRise == w * f * WB, "R2 total pulses", nRise, w * f * WB);
    chk(txIdx - base == w * f, "R2 words consumed", txIdx - base, w * f);
    chk(csRiseT[0] == lastF + h + 1, "R7 hold delay", csRiseT[0], lastF + h + 1);
    chk(nDone == 1, "R10 single done", nDone, 1);
    chk(doneT[0] == lastF + 1, "R10 done timing", doneT[0], lastF + 1);
    chk(busyFallT[0] == csRiseT[0] + ina + chg, "R8 busy through release time",
        busyFallT[0], csRiseT[0] + ina + chg);
  endtask

  task automatic testBackToBack();
    int base, lastF;
    clearRec();
    cfgDiv = VW'(0);
    cfgInactive = DW'(4);
    base = txIdx;
    sendCmd(1, 2, 1, 0, 3, 2, 3, 1'b0);
    sendCmd(2, 1, 2, 1, 0, 0, 0, 1'b0);
    waitIdle();
    chk(nCsFall == 2, "R10 second command waits", nCsFall, 2);
    chk(csFallT[1] - csRiseT[0] == 4 + 3 + 1, "R8 select release time",
        csFallT[1] - csRiseT[0], 8);
    checkXfer(0, base, csFallT[0] + 2, 1, 2, 0, 0, 3, "R4 setup delay", lastF);
    checkXfer(16, base + 2, csFallT[1] + 3, 2, 1, 0, 1, 0, "R4 setup delay", lastF);
  endtask

  task automatic testKeep();
    int base, lastF;
    clearRec();
    cfgDiv = VW'(2);
    cfgInactive = DW'(1);
    base = txIdx;
    sendCmd(2, 1, 20, 1, 0, 1, 0, 1'b1);
    sendCmd(1, 1, 20, 0, 0, 1, 0, 1'b0);
    waitIdle();
    chk(nCsFall == 1 && nCsRise == 1, "R9 select kept between transfers", nCsFall, 1);
    chk(nDone == 2, "R9 two done pulses", nDone, 2);
    chk(busyFallT[0] == doneT[0], "R9 busy falls with done", busyFallT[0], doneT[0]);
    checkXfer(0, base, csFallT[0] + 21, 2, 1, 2, 1, 0, "R4 setup delay", lastF);
    checkXfer(16, base + 2, doneT[0] + 2, 1, 1, 2, 0, 0, "R9 no setup after kept select", lastF);
    chk(csRiseT[0] == lastF + 2, "R7 hold after kept sequence", csRiseT[0], lastF + 2);
  endtask

  task automatic testRxStall();
    int heldRises;
    logic [WB-1:0] expW;
    clearRec();
    cfgDiv = VW'(0);
    cfgInactive = DW'(0);
    rxReady = 1'b0;
    expW = txWord(txIdx);
    sendCmd(2, 1, 0, 0, 0, 0, 0, 1'b0);
    @(negedge clk);
    while (!rxValid) @(negedge clk);
    repeat (20) @(negedge clk);
    heldRises = nRise;
    chk(heldRises == WB, "R11 no clock while word pending", heldRises, WB);
    chk(rxValid == 1'b1, "R11 rxValid held", rxValid, 1);
    chk(rxData == expW, "R11 rxData held", longint'(rxData), longint'(expW));
    rxReady = 1'b1;
    waitIdle();
    chk(nRise == 2 * WB, "R11 resumes after accept", nRise, 2 * WB);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic(0, 3, 3, 4, 2, 5, 3, 2, 3);
    testBasic(1, 2, 2, 0, 0, 0, 0, 0, 0);
    testBasic(3, 1, 2, 7, 0, 9, 6, 0, 5);
    testBackToBack();
    testKeep();
    testRxStall();
    chk(rxIdx == txIdx, "R2 every word returned", rxIdx, txIdx);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule